// File: doc/BRIEF.md
# Scan Clock Loss Monitor

This block guards a liquid-crystal panel against a DC bias. It watches one periodic pulse from the display controller, such as the frame scan start or the line latch. If no rising transition of that pulse arrives within a programmed number of system clocks, it drives an active-low blanking output. That output is meant for the row driver's blanking input, which forces every driver output to the safe rail. The display controller also supplies a display-enable input, which is ANDed with the monitor's own verdict, so a display-off request blanks the panel as well.

The monitored pulse crosses into the system clock domain through a synchronizer before its edge is detected. A counter of system clocks restarts on each detected edge and stands in for an analog charge-hold timer. After a loss, blanking ends only when two fresh edges arrive, the second within the timeout of the first. The monitor starts blanked out of reset. A spare two-input NAND gate with its own output is also included. The integrator ties its inputs low when the gate is unused.

Top module: `scan_loss_mon`

## Requirements
- R1: While `rst_ni` is low, and after it rises, `blank_no` is 0 until the release rule of R4 is met.
- R2: A 0-to-1 transition on `scan_i` passes through a two-flop synchronizer. It changes the monitor state at the third rising clock edge that samples `scan_i` high, and never earlier.
- R3: If edges arrive fewer than TIMEOUT clocks apart, `blank_no` stays 1. Once edges stop, `blank_no` falls to 0 at the clock edge TIMEOUT+3 clocks after the last edge was first sampled.
- R4: While blanked, a detected edge that arrives fewer than TIMEOUT clocks after the previous detected edge sets `blank_no` to 1, provided that previous edge was itself seen while blanked.
- R5: While blanked, a single edge does not release. An edge that follows its predecessor by TIMEOUT or more clocks only arms the monitor again, and blanking continues.
- R6: `disp_on_i` = 0 forces `blank_no` to 0 combinationally, in every monitor state. Setting it back to 1 restores the monitor's verdict.
- R7: `gate_o` equals NOT(`gate_a_i` AND `gate_b_i`), combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scan_i | input | 1 | Monitored controller pulse, asynchronous |
| disp_on_i | input | 1 | Display enable; 0 forces blanking |
| gate_a_i | input | 1 | Spare NAND input A |
| gate_b_i | input | 1 | Spare NAND input B |
| blank_no | output | 1 | Active-low blanking for the driver |
| gate_o | output | 1 | Spare NAND output |

## Verification
Faults in the counter or the state machine show up at `blank_no` within a bounded time.

- **Counter fault.** A counter that fails to restart shows as a spurious drop during a healthy pulse train. The drop comes within one timeout.
- **Missing halt.** A counter that never saturates shows as a missing drop after the pulses stop. The drop is due at clock TIMEOUT+3.
- **Missing arm step.** A state machine that skips arming releases on the first edge. This is seen three clocks after that edge.
- **Early or late release.** A synchronizer of the wrong depth moves the release by one clock. This is seen three clocks after the edge.

// File: rtl/scan_mon_pkg.sv
package scan_mon_pkg;
  typedef enum logic [1:0] {
    MON_RUN  = 2'd0,
    MON_HALT = 2'd1,
    MON_ARM  = 2'd2
  } mon_state_e;
endpackage

// File: rtl/scan_mon_sync.sv
module scan_mon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[g] <= 1'b0;
      else if (g == 0) stage_q[g] <= d_i;
      else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= stage_q[STAGES-1];
  end

  assign rise_o = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/scan_mon_timer.sv
module scan_mon_timer #(
  parameter int TIMEOUT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  output logic late_o
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt_q;

  // powers up expired so the monitor starts halted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= LIMIT;
    else if (rise_i) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign late_o = (cnt_q == LIMIT);
endmodule

// File: rtl/scan_mon_qual.sv
module scan_mon_qual
  import scan_mon_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic late_i,
  output logic halted_o
);
  mon_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (late_i) begin
      // an edge arriving late only arms
      state_d = rise_i ? MON_ARM : MON_HALT;
    end else if (rise_i) begin
      unique case (state_q)
        MON_HALT: state_d = MON_ARM;
        MON_ARM:  state_d = MON_RUN;
        default:  state_d = MON_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= MON_HALT;
    else state_q <= state_d;
  end

  assign halted_o = (state_q != MON_RUN);
endmodule

// File: rtl/scan_loss_mon.sv
module scan_loss_mon #(
  parameter int TIMEOUT     = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scan_i,
  input  logic disp_on_i,
  input  logic gate_a_i,
  input  logic gate_b_i,
  output logic blank_no,
  output logic gate_o
);
  logic rise, late, halted;

  scan_mon_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .d_i(scan_i), .rise_o(rise)
  );

  scan_mon_timer #(.TIMEOUT(TIMEOUT)) i_timer (
    .clk_i, .rst_ni, .rise_i(rise), .late_o(late)
  );

  scan_mon_qual i_qual (
    .clk_i, .rst_ni, .rise_i(rise), .late_i(late), .halted_o(halted)
  );

  assign blank_no = ~halted & disp_on_i;
  assign gate_o   = ~(gate_a_i & gate_b_i);
endmodule

// File: rtl/scan_loss_mon_chk.sv
module scan_loss_mon_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rise_i,
  input logic late_i,
  input logic halted_i,
  input logic disp_on_i,
  input logic blank_no
);
  // R3
  late_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_i |=> halted_i);

  // R3
  halt_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halted_i) |-> $past(late_i));

  // R4
  release_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(halted_i) |-> $past(rise_i) && !$past(late_i));

  // R1
  halted_blanks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |-> !blank_no);

  // R6
  disp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_on_i |-> !blank_no);
endmodule

bind scan_loss_mon scan_loss_mon_chk i_chk (
  .clk_i, .rst_ni, .rise_i(rise), .late_i(late), .halted_i(halted),
  .disp_on_i, .blank_no
);

// File: tb/test_scan_loss_mon.sv
`timescale 1ns/1ps
module test_scan_loss_mon;
  localparam int T = 20;

  logic clk = 1'b0;
  logic rst_ni, scan, disp_on, ga, gb;
  logic blank_n, gout;
  int   checks = 0, fails = 0;
  bit   done = 0;

  string tag_q[$];
  bit    eb_q[$];
  bit    en_q[$];
  event  chk_ev;

  always #2.5 clk = ~clk;

  scan_loss_mon #(.TIMEOUT(T), .SYNC_STAGES(2)) i_scan_loss_mon (
    .clk_i(clk), .rst_ni(rst_ni), .scan_i(scan), .disp_on_i(disp_on),
    .gate_a_i(ga), .gate_b_i(gb), .blank_no(blank_n), .gate_o(gout)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: push expected outputs, monitor compares
  task automatic expect_out(string tag, bit eb);
    #1;
    tag_q.push_back(tag);
    eb_q.push_back(eb);
    en_q.push_back(!(ga && gb));
    -> chk_ev;
    #0;
  endtask

  task automatic pulse();
    scan = 1'b1;
    step(2);
    scan = 1'b0;
  endtask

  initial begin
    forever begin
      @(chk_ev);
      while (tag_q.size() != 0) begin
        string t;
        bit eb, en;
        t  = tag_q.pop_front();
        eb = eb_q.pop_front();
        en = en_q.pop_front();
        checks++;
        if (blank_n !== eb || gout !== en) begin
          fails++;
          $display("FAIL %s: blank_no=%b gate_o=%b expected blank_no=%b gate_o=%b",
                   t, blank_n, gout, eb, en);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; scan = 1'b0; disp_on = 1'b1; ga = 1'b0; gb = 1'b0;
    step(3);
    expect_out("R1 in reset", 0);
    rst_ni = 1'b1;
    step(2);
    expect_out("R1 after reset", 0);

    for (int i = 0; i < 4; i++) begin
      ga = i[0]; gb = i[1];
      expect_out("R7 nand", 0);
    end
    ga = 1'b0; gb = 1'b0;
    step(1);

    // first edge arms only
    pulse();
    step(8);
    expect_out("R5 single edge", 0);
    pulse();
    expect_out("R2 not yet", 0);
    step(1);
    expect_out("R4 release", 1);
    step(7);

    // healthy train, period 10 < T
    for (int i = 0; i < 6; i++) begin
      pulse();
      step(3);
      expect_out("R3 train", 1);
      if (i == 2) begin
        disp_on = 1'b0;
        expect_out("R6 display off", 0);
        disp_on = 1'b1;
        expect_out("R6 restore", 1);
      end
      step(5);
    end

    // pulses stop: 10 clocks since last raise
    step(T + 3 - 10);
    expect_out("R3 before timeout", 1);
    step(1);
    expect_out("R3 timeout", 0);

    // late second edge re-arms
    step(5);
    pulse();
    step(T + 3);
    pulse();
    step(1);
    expect_out("R5 late edge", 0);
    step(7);
    pulse();
    step(1);
    expect_out("R4 third edge", 1);
    step(6);

    // reset while running
    rst_ni = 1'b0;
    expect_out("R1 mid-run reset", 0);
    step(1);
    rst_ni = 1'b1;
    step(1);
    pulse();
    step(8);
    expect_out("R5 after reset", 0);
    pulse();
    expect_out("R2 after reset", 0);
    step(1);
    expect_out("R4 after reset", 1);

    step(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule